// File: doc/BRIEF.md
# Multi-Reader Stream Buffer Controller

This block holds the data of one producer-to-consumers edge of a streaming task graph. A single producer pushes words into a circular buffer. Up to four consumers each read the same sequence of words at their own pace. Each consumer has an independent read position. A consumer's words are copied out by a block-transfer engine, which asks for a burst on a pull port. The granted burst is then streamed out on a read port. Each word on that port carries a tag that names the consumer it belongs to.

For each consumer the block reports the number of words it has not yet received. This count acts as that consumer's semaphore. The block also reports the free space seen by the producer. A buffer slot is reused only after every consumer has moved past it. The free space is therefore set by the slowest reader.

All three data interfaces use valid/ready. A word or request moves on a cycle where both valid and ready are high. The producer may hold `wr_valid` for as long as it likes: `wr_ready` depends only on the stored state. `pull_ready` depends on the stored state and on the request fields, and never on `pull_valid`. Once `rd_valid` is high, it stays high and the tag, data and last flag stay constant until the word is taken. The read side may hold `rd_ready` low for any number of cycles.

Top module: `fanout_stream_fifo`

## Requirements
- R1: After reset, every consumer's available count is 0, the free count equals DEPTH, `wr_ready` is high, `rd_valid` is low and `pull_ready` is low for every request.
- R2: `wr_ready` is high exactly when the free count is nonzero. A write (`wr_valid` and `wr_ready` both high) raises every consumer's available count by one on the next cycle. A write offered while `wr_ready` is low is ignored.
- R3: Consumer c's available count sits at bits [c*(AW+1) +: AW+1] of `avail_cnt`, where AW = log2(DEPTH). It equals the number of words written minus the number of words delivered to consumer c.
- R4: The free count equals DEPTH minus the largest available count over all consumers.
- R5: `pull_ready` is high only when no burst is in progress, `pull_cons` is below NUM_CONS, and `pull_len` is at least 1 and at most that consumer's available count. In every other case the request is not taken.
- R6: After a pull is taken, the read port delivers exactly `pull_len` words, one per accepted cycle. Each word is tagged with that consumer in `rd_cons`. The words are that consumer's next unread words in write order. `rd_last` is high on the final word, and `rd_valid` is low on the cycle after the final word is taken.
- R7: While `rd_valid` is high and `rd_ready` is low, `rd_valid`, `rd_data`, `rd_cons` and `rd_last` stay unchanged on the next cycle.
- R8: Each word taken on the read port lowers only the tagged consumer's available count by one, on the next cycle.
- R9: Reading by any consumer other than the one with the largest available count leaves the free count unchanged. Space returns only as the slowest reader advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Producer offers a word |
| wr_ready | output | 1 | Buffer has a free slot |
| wr_data | input | DATA_W | Producer word |
| pull_valid | input | 1 | Transfer engine requests a burst |
| pull_ready | output | 1 | Burst request granted this cycle |
| pull_cons | input | CIDW | Consumer that the burst is for |
| pull_len | input | AW+1 | Burst length in words |
| rd_valid | output | 1 | Burst word present |
| rd_ready | input | 1 | Transfer engine takes the word |
| rd_data | output | DATA_W | Burst word |
| rd_cons | output | CIDW | Consumer tag of the burst word |
| rd_last | output | 1 | Final word of the burst |
| avail_cnt | output | NUM_CONS*(AW+1) | Per-consumer available counts |
| free_cnt | output | AW+1 | Free slots seen by the producer |

## Verification
The bench builds the block with DEPTH 8, NUM_CONS 3 and a 16-bit data width. The small depth means the buffer fills within a few cycles and the pointers wrap many times during a run. This exercises the extra wrap bit and the case where the buffer is full. With three consumers, the two-bit consumer field can carry the value 3, which is out of range, so the rejection of a request for a consumer that does not exist can be tested. Directed phases fill the buffer, offer rejected requests, and drain the consumers unevenly so that free space returns only with the slowest reader. A long random phase then mixes all of these.

// File: rtl/fsf_pkg.sv
package fsf_pkg;

  typedef enum logic {
    BURST_IDLE = 1'b0,
    BURST_RUN  = 1'b1
  } burst_state_e;

  function automatic int fsf_idw(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/fsf_mem.sv
module fsf_mem #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  assign rdata = store[raddr];

endmodule

// File: rtl/fsf_occupancy.sv
module fsf_occupancy #(
  parameter int DEPTH    = 16,
  parameter int NUM_CONS = 4,
  localparam int PW      = $clog2(DEPTH) + 1
) (
  input  logic [PW-1:0]          wptr,
  input  logic [NUM_CONS*PW-1:0] rptr_flat,
  output logic [NUM_CONS*PW-1:0] avail_flat,
  output logic [PW-1:0]          free_cnt
);

  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

  logic [PW-1:0] occ [NUM_CONS];
  logic [PW-1:0] max_occ;

  for (genvar c = 0; c < NUM_CONS; c++) begin : g_occ
    assign occ[c] = wptr - rptr_flat[c*PW +: PW];
    assign avail_flat[c*PW +: PW] = occ[c];
  end

  always_comb begin
    max_occ = '0;
    for (int c = 0; c < NUM_CONS; c++) begin
      if (occ[c] > max_occ) max_occ = occ[c];
    end
  end

  assign free_cnt = DEPTH_P - max_occ;

endmodule

// File: rtl/fsf_burst.sv
module fsf_burst
  import fsf_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int NUM_CONS = 4,
  localparam int PW      = $clog2(DEPTH) + 1,
  localparam int CIDW    = fsf_idw(NUM_CONS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   pull_valid,
  input  logic [CIDW-1:0]        pull_cons,
  input  logic [PW-1:0]          pull_len,
  output logic                   pull_ready,
  input  logic [NUM_CONS*PW-1:0] avail_flat,
  input  logic                   rd_ready,
  output logic                   rd_valid,
  output logic                   rd_last,
  output logic [CIDW-1:0]        rd_cons,
  output logic [PW-1:0]          rd_ptr,
  output logic [NUM_CONS*PW-1:0] rptr_flat
);

  burst_state_e  state;
  logic [CIDW-1:0] cur;
  logic [PW-1:0] rem;
  logic [PW-1:0] req_avail;
  logic          req_in_range;
  logic          grant;
  logic          take;

  always_comb begin
    req_avail    = '0;
    req_in_range = 1'b0;
    for (int c = 0; c < NUM_CONS; c++) begin
      if (int'(pull_cons) == c) begin
        req_avail    = avail_flat[c*PW +: PW];
        req_in_range = 1'b1;
      end
    end
  end

  assign pull_ready = (state == BURST_IDLE) && req_in_range &&
                      (pull_len != '0) && (pull_len <= req_avail);
  assign grant    = pull_valid && pull_ready;
  assign rd_valid = (state == BURST_RUN);
  assign take     = rd_valid && rd_ready;
  assign rd_last  = (rem == PW'(1));
  assign rd_cons  = cur;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= BURST_IDLE;
      cur   <= '0;
      rem   <= '0;
    end else if (grant) begin
      state <= BURST_RUN;
      cur   <= pull_cons;
      rem   <= pull_len;
    end else if (take) begin
      rem <= rem - PW'(1);
      if (rd_last) state <= BURST_IDLE;
    end
  end

  for (genvar c = 0; c < NUM_CONS; c++) begin : g_rptr
    logic [PW-1:0] rp;
    always_ff @(posedge clk) begin
      if (!rst_n)                         rp <= '0;
      else if (take && cur == CIDW'(c))   rp <= rp + PW'(1);
    end
    assign rptr_flat[c*PW +: PW] = rp;
  end

  always_comb begin
    rd_ptr = '0;
    for (int c = 0; c < NUM_CONS; c++) begin
      if (int'(cur) == c) rd_ptr = rptr_flat[c*PW +: PW];
    end
  end

endmodule

// File: rtl/fanout_stream_fifo.sv
module fanout_stream_fifo
  import fsf_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int DEPTH    = 16,
  parameter int NUM_CONS = 4,
  localparam int AW      = $clog2(DEPTH),
  localparam int PW      = AW + 1,
  localparam int CIDW    = fsf_idw(NUM_CONS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_valid,
  output logic                   wr_ready,
  input  logic [DATA_W-1:0]      wr_data,
  input  logic                   pull_valid,
  output logic                   pull_ready,
  input  logic [CIDW-1:0]        pull_cons,
  input  logic [PW-1:0]          pull_len,
  output logic                   rd_valid,
  input  logic                   rd_ready,
  output logic [DATA_W-1:0]      rd_data,
  output logic [CIDW-1:0]        rd_cons,
  output logic                   rd_last,
  output logic [NUM_CONS*PW-1:0] avail_cnt,
  output logic [PW-1:0]          free_cnt
);

  logic [PW-1:0]          wptr;
  logic [PW-1:0]          rd_ptr;
  logic [NUM_CONS*PW-1:0] rptr_flat;
  logic                   wr_fire;

  assign wr_ready = (free_cnt != '0);
  assign wr_fire  = wr_valid && wr_ready;

  always_ff @(posedge clk) begin
    if (!rst_n)       wptr <= '0;
    else if (wr_fire) wptr <= wptr + PW'(1);
  end

  fsf_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
    .clk   (clk),
    .we    (wr_fire),
    .waddr (wptr[AW-1:0]),
    .wdata (wr_data),
    .raddr (rd_ptr[AW-1:0]),
    .rdata (rd_data)
  );

  fsf_occupancy #(.DEPTH(DEPTH), .NUM_CONS(NUM_CONS)) u_occ (
    .wptr       (wptr),
    .rptr_flat  (rptr_flat),
    .avail_flat (avail_cnt),
    .free_cnt   (free_cnt)
  );

  fsf_burst #(.DEPTH(DEPTH), .NUM_CONS(NUM_CONS)) u_burst (
    .clk        (clk),
    .rst_n      (rst_n),
    .pull_valid (pull_valid),
    .pull_cons  (pull_cons),
    .pull_len   (pull_len),
    .pull_ready (pull_ready),
    .avail_flat (avail_cnt),
    .rd_ready   (rd_ready),
    .rd_valid   (rd_valid),
    .rd_last    (rd_last),
    .rd_cons    (rd_cons),
    .rd_ptr     (rd_ptr),
    .rptr_flat  (rptr_flat)
  );

endmodule

// File: rtl/fsf_checker.sv
module fsf_checker
  import fsf_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int DEPTH    = 16,
  parameter int NUM_CONS = 4,
  localparam int PW      = $clog2(DEPTH) + 1,
  localparam int CIDW    = fsf_idw(NUM_CONS)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   wr_valid,
  input logic                   wr_ready,
  input logic                   pull_valid,
  input logic                   pull_ready,
  input logic [CIDW-1:0]        pull_cons,
  input logic [PW-1:0]          pull_len,
  input logic                   rd_valid,
  input logic                   rd_ready,
  input logic [DATA_W-1:0]      rd_data,
  input logic [CIDW-1:0]        rd_cons,
  input logic                   rd_last,
  input logic [NUM_CONS*PW-1:0] avail_cnt,
  input logic [PW-1:0]          free_cnt
);

  logic [PW-1:0] chk_avail;
  always_comb begin
    chk_avail = '0;
    for (int c = 0; c < NUM_CONS; c++) begin
      if (int'(pull_cons) == c) chk_avail = avail_cnt[c*PW +: PW];
    end
  end

  // R2: a full buffer refuses the producer
  a_r2_full_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
    (free_cnt == '0) |-> !wr_ready);

  // R4: free space never exceeds the depth
  a_r4_free_bound: assert property (@(posedge clk) disable iff (!rst_n)
    free_cnt <= PW'(DEPTH));

  // R5: a granted burst fits in the consumer's available words
  a_r5_grant_fits: assert property (@(posedge clk) disable iff (!rst_n)
    (pull_valid && pull_ready) |-> (pull_len != '0 && pull_len <= chk_avail));

  // R5: no grant while a burst is streaming
  a_r5_idle_grant: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !pull_ready);

  // R7: a stalled word holds
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data) &&
                                 $stable(rd_cons) && $stable(rd_last)));

  // R6: the burst ends after its last word is taken
  a_r6_last_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready && rd_last) |=> !rd_valid);

endmodule

bind fanout_stream_fifo fsf_checker #(
  .DATA_W(DATA_W), .DEPTH(DEPTH), .NUM_CONS(NUM_CONS)
) u_fsf_checker (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .pull_valid(pull_valid), .pull_ready(pull_ready), .pull_cons(pull_cons),
  .pull_len(pull_len), .rd_valid(rd_valid), .rd_ready(rd_ready),
  .rd_data(rd_data), .rd_cons(rd_cons), .rd_last(rd_last),
  .avail_cnt(avail_cnt), .free_cnt(free_cnt)
);

// File: tb/fanout_stream_fifo_bench.sv
module fanout_stream_fifo_bench;

  localparam int DW   = 16;
  localparam int DEP  = 8;
  localparam int NC   = 3;
  localparam int PW   = $clog2(DEP) + 1;
  localparam int CIDW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0;
  logic wr_ready;
  logic [DW-1:0] wr_data = '0;
  logic pull_valid = 1'b0;
  logic pull_ready;
  logic [CIDW-1:0] pull_cons = '0;
  logic [PW-1:0] pull_len = '0;
  logic rd_valid;
  logic rd_ready = 1'b0;
  logic [DW-1:0] rd_data;
  logic [CIDW-1:0] rd_cons;
  logic rd_last;
  logic [NC*PW-1:0] avail_cnt;
  logic [PW-1:0] free_cnt;

  always #2 clk = ~clk;

  fanout_stream_fifo #(.DATA_W(DW), .DEPTH(DEP), .NUM_CONS(NC)) u_fanout_stream_fifo (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .pull_valid(pull_valid), .pull_ready(pull_ready),
    .pull_cons(pull_cons), .pull_len(pull_len), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_data(rd_data), .rd_cons(rd_cons),
    .rd_last(rd_last), .avail_cnt(avail_cnt), .free_cnt(free_cnt)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference model
  int wp;
  int rp [NC];
  logic [DW-1:0] mdata [DEP];
  bit busy;
  int cur, rem;
  bit hold_prev;
  logic [DW-1:0] hold_data;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int m_avail(input int c);
    return wp - rp[c];
  endfunction

  function automatic int m_free();
    int mx = 0;
    for (int c = 0; c < NC; c++) if (m_avail(c) > mx) mx = m_avail(c);
    return DEP - mx;
  endfunction

  function automatic bit m_pull_ok(input int pc, input int pl);
    if (busy) return 0;
    if (pc >= NC) return 0;
    if (pl < 1) return 0;
    return pl <= m_avail(pc);
  endfunction

  task automatic step(input bit wv, input int wd, input bit pv, input int pc,
                      input int pl, input bit rr);
    bit wf, pf, rf;
    @(negedge clk);
    wr_valid = wv; wr_data = DW'(wd);
    pull_valid = pv; pull_cons = CIDW'(pc); pull_len = PW'(pl);
    rd_ready = rr;
    #1;
    for (int c = 0; c < NC; c++)
      chk(int'(avail_cnt[c*PW +: PW]) == m_avail(c), "R3 R8 avail",
          int'(avail_cnt[c*PW +: PW]), m_avail(c));
    chk(int'(free_cnt) == m_free(), "R4 R9 free", int'(free_cnt), m_free());
    chk(wr_ready == (m_free() > 0), "R2 wr_ready", int'(wr_ready), int'(m_free() > 0));
    chk(pull_ready == m_pull_ok(pc, pl), "R5 pull_ready", int'(pull_ready),
        int'(m_pull_ok(pc, pl)));
    chk(rd_valid == busy, "R6 rd_valid", int'(rd_valid), int'(busy));
    if (busy) begin
      chk(int'(rd_cons) == cur, "R6 rd_cons", int'(rd_cons), cur);
      chk(rd_data == mdata[rp[cur] % DEP], "R6 rd_data", int'(rd_data),
          int'(mdata[rp[cur] % DEP]));
      chk(rd_last == (rem == 1), "R6 rd_last", int'(rd_last), int'(rem == 1));
    end
    if (hold_prev)
      chk(rd_valid && rd_data == hold_data, "R7 hold", int'(rd_data), int'(hold_data));
    hold_prev = busy && !rr;
    hold_data = rd_data;
    wf = wv && (m_free() > 0);
    pf = pv && m_pull_ok(pc, pl);
    rf = busy && rr;
    if (rf) begin
      rp[cur]++; rem--;
      if (rem == 0) busy = 0;
    end
    if (wf) begin
      mdata[wp % DEP] = DW'(wd);
      wp++;
    end
    if (pf) begin
      busy = 1; cur = pc; rem = pl;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7331));
    wp = 0; busy = 0; cur = 0; rem = 0; hold_prev = 0;
    for (int c = 0; c < NC; c++) rp[c] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    for (int c = 0; c < NC; c++)
      chk(avail_cnt[c*PW +: PW] == '0, "R1 avail", int'(avail_cnt[c*PW +: PW]), 0);
    chk(int'(free_cnt) == DEP, "R1 free", int'(free_cnt), DEP);
    chk(wr_ready == 1'b1, "R1 wr_ready", int'(wr_ready), 1);
    chk(rd_valid == 1'b0, "R1 rd_valid", int'(rd_valid), 0);
    pull_valid = 1'b1; pull_cons = 0; pull_len = 1;
    #1;
    chk(pull_ready == 1'b0, "R1 pull_ready", int'(pull_ready), 0);

    // R2: fill past full, extra writes ignored
    for (int i = 0; i < DEP + 3; i++) step(1, 16'h100 + i, 0, 0, 0, 0);
    // R5: rejected requests (bad consumer, zero length, too long)
    step(0, 0, 1, 3, 1, 0);
    step(0, 0, 1, 0, 0, 0);
    step(0, 0, 1, 1, DEP + 1, 0);
    // R9: consumer 0 drains fully, free must stay zero
    step(0, 0, 1, 0, DEP, 0);
    for (int i = 0; i < DEP + 1; i++) step(0, 0, 0, 0, 0, 1);
    // R7: consumer 1 reads 4 with stalls
    step(0, 0, 1, 1, 4, 0);
    for (int i = 0; i < 10; i++) step(0, 0, 0, 0, 0, i[0]);
    // R9: consumer 2 reads all, free returns as consumer 1 now lags
    step(1, 16'h200, 1, 2, DEP, 1);
    for (int i = 0; i < DEP + 2; i++) step(0, 0, 0, 0, 0, 1);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      step(($urandom % 10) < 7, int'($urandom % 65536),
           ($urandom % 10) < 4, int'($urandom % 4),
           int'($urandom % (DEP + 2)), ($urandom % 10) < 6);
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule